// File: doc/BRIEF.md
# Bit-Clock to Frame-Clock Ratio Monitor

This block watches a bit clock and a frame clock that an external device supplies to a serial audio port in slave operation. Both arrive asynchronously to the logic, so the block re-times them into the master clock domain. It then counts bit-clock rising edges over each full frame, measured from one frame-clock rising edge to the next, and reports that count as the measured ratio.

Each measurement is checked against the set of ratios that the selected speed mode allows. Single speed accepts a wider set than the double and quad speed modes. A lock flag rises once two frames in a row give the same legal count. A one-cycle error pulse flags any illegal count, and any legal count that differs from the one before it. A frame clock that stops makes the edge counter saturate, so the block reports an illegal ratio and never a wrapped, plausible-looking value.

Top module: `bitclk_ratio_monitor`

## Requirements
- R1: While reset is high and in the cycle after it, `ratio_o` is 0, `lock_o` is 0 and `err_o` is 0.
- R2: The block counts bit-clock rising edges between two consecutive frame-clock rising edges. It loads that count into `ratio_o` on each measurement and holds `ratio_o` between measurements.
- R3: The first frame-clock rising edge after reset only starts a count. It produces no measurement, no error and no change of `ratio_o`.
- R4: `speed_i` encoding: 2'b00 single speed, 2'b01 double speed, 2'b10 quad speed, 2'b11 handled as quad speed. In single speed, the counts 32, 48, 64 and 128 are legal.
- R5: In the other three encodings, only 32, 48 and 64 are legal. A count of 128 is illegal there.
- R6: `lock_o` rises only after two consecutive measurements are equal and legal. A single legal measurement after reset or after an illegal one leaves `lock_o` low.
- R7: An illegal measurement gives a one-cycle pulse on `err_o`, clears `lock_o`, and discards the stored reference count.
- R8: A legal measurement that differs from the stored reference gives a one-cycle pulse on `err_o` and clears `lock_o`. The new count becomes the reference, and the next equal measurement locks again.
- R9: The edge counter saturates at 255. A frame longer than 255 bit-clock periods is reported as 255 and is treated as illegal.
- R10: `ratio_o`, `lock_o` and `err_o` reflect a completed frame no later than 4 master-clock cycles after the frame-clock input rises. This latency comes from two synchronizer stages, the edge detector and the measurement register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk_i | input | 1 | Master clock; all logic runs on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| bit_clk_i | input | 1 | Externally supplied serial bit clock (asynchronous) |
| frame_clk_i | input | 1 | Externally supplied frame (left/right) clock (asynchronous) |
| speed_i | input | 2 | Speed mode: 00 single, 01 double, 10 quad, 11 as quad |
| ratio_o | output | 8 | Bit-clock rising edges counted in the last full frame |
| lock_o | output | 1 | Two consecutive equal legal measurements seen |
| err_o | output | 1 | One-cycle pulse on an illegal or changed measurement |

## Verification
The bench sweeps every speed encoding against legal and illegal frame lengths (24, 32, 48, 64, 96 and 128 bit clocks). A design that got the mode table wrong would lock at 128 in double or quad speed, or would flag 128 in single speed. The first partial frame after reset is checked for silence; a block that reported it would raise a spurious error before the stream is even aligned. A switch from 64 to 32 bit clocks per frame must give exactly one error and then relock, which catches a tracker that never updates its reference. A frame of 300 bit clocks must read 255, where a wrapping counter would show 44.

// File: rtl/brm_pkg.sv
package brm_pkg;

    typedef enum logic [1:0] {
        SPD_SINGLE = 2'b00,
        SPD_DOUBLE = 2'b01,
        SPD_QUAD   = 2'b10,
        SPD_RSVD   = 2'b11
    } speed_e;

    localparam int CNT_W = 8;
    localparam int SYNC_STAGES = 2;

    typedef logic [CNT_W-1:0] cnt_t;

    localparam cnt_t CNT_MAX = '1;

    // one completed frame measurement
    typedef struct packed {
        logic valid;
        cnt_t count;
    } meas_t;

    // result of comparing a measurement with the stored reference
    typedef enum logic [1:0] {
        CMP_ILLEGAL,
        CMP_FIRST,
        CMP_MATCH,
        CMP_CHANGED
    } cmp_e;

    function automatic logic ratio_legal(cnt_t c, speed_e m);
        logic base;
        base = (c == cnt_t'(32)) || (c == cnt_t'(48)) || (c == cnt_t'(64));
        return base || ((m == SPD_SINGLE) && (c == cnt_t'(128)));
    endfunction

endpackage

// File: rtl/brm_sync_edge.sv
module brm_sync_edge #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] rise_o
);

    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '0;
            end
            prev_q <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
            prev_q <= stage_q[LAST];
        end
    end

    for (genvar b = 0; b < WIDTH; b++) begin : g_edge
        assign rise_o[b] = stage_q[LAST][b] & ~prev_q[b];
    end

endmodule

// File: rtl/brm_frame_counter.sv
module brm_frame_counter
    import brm_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  bit_rise_i,
    input  logic  frame_rise_i,
    output meas_t meas_o,
    output cnt_t  run_cnt_o
);

    cnt_t  run_q;
    logic  armed_q;
    meas_t meas_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            run_q   <= '0;
            armed_q <= 1'b0;
            meas_q  <= '0;
        end else begin
            meas_q.valid <= 1'b0;
            if (frame_rise_i) begin
                armed_q <= 1'b1;
                if (armed_q) begin
                    meas_q.valid <= 1'b1;
                    meas_q.count <= run_q;
                end
                run_q <= bit_rise_i ? cnt_t'(1) : '0;
            end else if (bit_rise_i && (run_q != CNT_MAX)) begin
                run_q <= run_q + cnt_t'(1);
            end
        end
    end

    assign meas_o    = meas_q;
    assign run_cnt_o = run_q;

endmodule

// File: rtl/brm_lock_tracker.sv
module brm_lock_tracker
    import brm_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  meas_t  meas_i,
    input  speed_e speed_i,
    output cnt_t   ratio_o,
    output logic   lock_o,
    output logic   err_o
);

    cnt_t ref_q;
    logic ref_ok_q;
    cnt_t ratio_q;
    logic lock_q;
    logic err_q;
    cmp_e cmp;

    always_comb begin
        if (!ratio_legal(meas_i.count, speed_i)) begin
            cmp = CMP_ILLEGAL;
        end else if (!ref_ok_q) begin
            cmp = CMP_FIRST;
        end else if (meas_i.count == ref_q) begin
            cmp = CMP_MATCH;
        end else begin
            cmp = CMP_CHANGED;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ref_q    <= '0;
            ref_ok_q <= 1'b0;
            ratio_q  <= '0;
            lock_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            err_q <= 1'b0;
            if (meas_i.valid) begin
                ratio_q <= meas_i.count;
                unique case (cmp)
                    CMP_ILLEGAL: begin
                        lock_q   <= 1'b0;
                        err_q    <= 1'b1;
                        ref_ok_q <= 1'b0;
                    end
                    CMP_FIRST: begin
                        ref_q    <= meas_i.count;
                        ref_ok_q <= 1'b1;
                    end
                    CMP_MATCH: begin
                        lock_q <= 1'b1;
                    end
                    CMP_CHANGED: begin
                        lock_q <= 1'b0;
                        err_q  <= 1'b1;
                        ref_q  <= meas_i.count;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign ratio_o = ratio_q;
    assign lock_o  = lock_q;
    assign err_o   = err_q;

endmodule

// File: rtl/bitclk_ratio_monitor.sv
module bitclk_ratio_monitor
    import brm_pkg::*;
(
    input  logic       mclk_i,
    input  logic       rst_i,
    input  logic       bit_clk_i,
    input  logic       frame_clk_i,
    input  logic [1:0] speed_i,
    output logic [7:0] ratio_o,
    output logic       lock_o,
    output logic       err_o
);

    logic [1:0] rise;
    logic       bit_rise;
    logic       frame_rise;
    meas_t      meas;
    cnt_t       run_cnt;
    cnt_t       ratio;

    brm_sync_edge #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i   (mclk_i),
        .rst_i   (rst_i),
        .async_i ({frame_clk_i, bit_clk_i}),
        .rise_o  (rise)
    );

    assign bit_rise   = rise[0];
    assign frame_rise = rise[1];

    brm_frame_counter u_count (
        .clk_i        (mclk_i),
        .rst_i        (rst_i),
        .bit_rise_i   (bit_rise),
        .frame_rise_i (frame_rise),
        .meas_o       (meas),
        .run_cnt_o    (run_cnt)
    );

    brm_lock_tracker u_track (
        .clk_i   (mclk_i),
        .rst_i   (rst_i),
        .meas_i  (meas),
        .speed_i (speed_e'(speed_i)),
        .ratio_o (ratio),
        .lock_o  (lock_o),
        .err_o   (err_o)
    );

    assign ratio_o = ratio;

endmodule

// File: rtl/bitclk_ratio_monitor_chk.sv
module bitclk_ratio_monitor_chk
    import brm_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [1:0] speed,
    input logic       frame_rise,
    input logic       meas_valid,
    input cnt_t       run_cnt,
    input logic [7:0] ratio,
    input logic       lock,
    input logic       err
);

    p_reset_state_r1: assert property (@(posedge clk)
        $past(rst) |-> (ratio == 8'd0 && !lock && !err));

    p_ratio_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !meas_valid |=> $stable(ratio));

    p_lock_legal_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(lock) |-> ratio_legal(ratio, speed_e'($past(speed))));

    p_err_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        err |=> !err);

    p_err_unlock_r8: assert property (@(posedge clk) disable iff (rst)
        err |-> !lock);

    p_sat_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (run_cnt == CNT_MAX && !frame_rise) |=> run_cnt == CNT_MAX);

endmodule

bind bitclk_ratio_monitor bitclk_ratio_monitor_chk u_chk (
    .clk        (mclk_i),
    .rst        (rst_i),
    .speed      (speed_i),
    .frame_rise (frame_rise),
    .meas_valid (meas.valid),
    .run_cnt    (run_cnt),
    .ratio      (ratio_o),
    .lock       (lock_o),
    .err        (err_o)
);

// File: tb/bitclk_ratio_monitor_test.sv
module bitclk_ratio_monitor_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bclk = 1'b0;
    logic       fclk = 1'b0;
    logic [1:0] speed = 2'b00;
    logic [7:0] ratio;
    logic       lock;
    logic       err;

    int tests = 0;
    int fails = 0;
    int err_seen = 0;
    int snap_ratio = 0;
    int snap_lock = 0;
    int snap_err = 0;

    always #2 clk = ~clk;

    bitclk_ratio_monitor uut (
        .mclk_i      (clk),
        .rst_i       (rst),
        .bit_clk_i   (bclk),
        .frame_clk_i (fclk),
        .speed_i     (speed),
        .ratio_o     (ratio),
        .lock_o      (lock),
        .err_o       (err)
    );

    always @(negedge clk) begin
        if (rst) err_seen = 0;
        else if (err) err_seen = err_seen + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        bclk = 1'b0;
        fclk = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // one frame of n bit clocks, bit clock period 4 master cycles,
    // frame clock rising with a falling bit-clock edge
    task automatic frame(input int n);
        for (int i = 0; i < 4 * n; i++) begin
            @(negedge clk);
            if (i == 5) begin
                snap_ratio = ratio;
                snap_lock  = lock;
                snap_err   = err_seen;
            end
            fclk = (i < 2 * n);
            bclk = ((i % 4) >= 2);
        end
    endtask

    function automatic int legal(input int r, input int m);
        return (r == 32 || r == 48 || r == 64) || (r == 128 && m == 0);
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int ratios [6] = '{24, 32, 48, 64, 96, 128};

        do_reset();
        @(negedge clk);
        chk("R1 ratio after reset", ratio, 0);
        chk("R1 lock after reset", lock, 0);
        chk("R1 err after reset", err, 0);

        // sweep every speed code over legal and illegal frame lengths
        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 6; k++) begin
                int r;
                int ok;
                r  = ratios[k];
                ok = legal(r, m);
                speed = m[1:0];
                do_reset();
                frame(r);
                chk($sformatf("R3 no report on first edge m=%0d r=%0d", m, r), snap_err, 0);
                chk($sformatf("R3 ratio idle m=%0d r=%0d", m, r), snap_ratio, 0);
                frame(r);
                chk($sformatf("R2 R10 ratio m=%0d r=%0d", m, r), snap_ratio, r);
                chk($sformatf("R6 no lock after one m=%0d r=%0d", m, r), snap_lock, 0);
                chk($sformatf("R7 err count after one m=%0d r=%0d", m, r), snap_err, ok ? 0 : 1);
                frame(r);
                frame(r);
                if (m == 0) begin
                    chk($sformatf("R4 lock single r=%0d", r), snap_lock, ok);
                end else begin
                    chk($sformatf("R5 lock m=%0d r=%0d", m, r), snap_lock, ok);
                end
                chk($sformatf("R7 err count m=%0d r=%0d", m, r), snap_err, ok ? 0 : 3);
            end
        end

        // change of a legal ratio
        speed = 2'b00;
        do_reset();
        frame(64); frame(64); frame(64); frame(32);
        chk("R8 locked before change", snap_lock, 1);
        frame(32);
        chk("R8 lock cleared on change", snap_lock, 0);
        chk("R8 one error on change", snap_err, 1);
        chk("R8 new ratio", snap_ratio, 32);
        frame(32);
        chk("R8 relock on new ratio", snap_lock, 1);
        chk("R8 no further error", snap_err, 1);

        // missing frame edge: counter saturates
        do_reset();
        frame(64); frame(64); frame(64); frame(300);
        chk("R9 locked before long frame", snap_lock, 1);
        frame(64);
        chk("R9 saturated ratio", snap_ratio, 255);
        chk("R9 lock cleared", snap_lock, 0);
        chk("R9 error on long frame", snap_err, 1);
        frame(64);
        chk("R7 reference discarded, no lock", snap_lock, 0);
        chk("R7 no error on first legal", snap_err, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule